// File: doc/BRIEF.md
# MSI-X vector table controller

This block owns the message-signalled interrupt state of one function: a per-vector table of message address, message data and control words, plus a pending-bit array. Both live in a single 4 KB register page that software reaches through a dword-only register bus. Device logic raises an interrupt request for a vector by index. The block either sends a memory-write message (64-bit address, 32-bit data) on a valid/ready output, or, when that vector is masked, records it as pending. A masked vector whose mask is later lifted has its message sent at that point.

Two capability control bits, enable and function mask, come in over a small configuration-write port. Writing the control byte with enable set pulses a clear request for the legacy interrupt line. If the function mask is also clear, every configured vector is rescanned for a pending message to replay. Device logic also keeps a use reference count per vector, and requests are delivered only for vectors that are in use. The number of configured vectors is the parameter `NUM_VEC`, which must lie between 1 and 32.

Top module: `vecmsg_ctrl`

## Requirements
- R1: Vector v owns the 16-byte slot at page offset 16*v. The words in the slot are at +0 (low address), +4 (high address), +8 (data) and +12 (control, bit 0 = vector mask). Each word can be written and read back. Read data appears on `bus_rdata` in the cycle after the request.
- R2: Only accesses with `bus_full`=1 take effect, and the offset used is `bus_addr[11:2]`. A narrow read returns 0 and a narrow write changes nothing.
- R3: The dword at offset 0x800 returns the pending bits, with bit v set for vector v (byte v/8, bit v%8). Every other dword in the upper half of the page reads 0. Table slots of vectors at or above `NUM_VEC` read 0. Writes to either region are ignored.
- R4: After reset, enable and function mask are 0 and all use counts are 0. No message is offered. Every table word is 0 except the control word of each configured vector, which reads 1.
- R5: A request whose index is at or above `NUM_VEC`, or whose vector has a use count of 0, is discarded. It sends no message and sets no pending bit.
- R6: A vector is masked when the function mask or its own control bit 0 is set. A request for a masked vector that is in use sets its pending bit and sends nothing.
- R7: A request for an unmasked vector that is in use sends one message, with `msg_addr` = {high, low} and `msg_data` = data. The enable bit does not gate this. While `msg_valid` is high and `msg_ready` is low, the payload holds steady. No message is sent without a cause.
- R8: After any table dword write to vector v, the block checks v. If v is then unmasked and pending, its pending bit is cleared and its message is sent.
- R9: On a control write, `cfg_ctrl_wdata[0]` is the enable and `cfg_ctrl_wdata[1]` is the function mask. If enable is written as 1, `intx_clr` pulses in the next cycle. If the function mask is also written as 0, all configured vectors are checked in ascending order, one per accepted output slot. Each one that is unmasked and pending is replayed and its pending bit is cleared. Control bits change only on a control write.
- R10: `use_inc` and `use_dec` step the use count of `use_vec`. Out-of-range indices are ignored, a decrement at 0 is ignored, and the count saturates at its maximum. A decrement that takes the count to 0 clears that vector's pending bit.
- R11: A request that arrives while a check is in progress or the output is stalled waits in a one-deep holder and is serviced afterwards. A request that arrives while the holder is occupied is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = full 32-bit access |
| bus_addr | input | 12 | Byte offset in the page |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cfg_ctrl_we | input | 1 | Write to the capability control byte |
| cfg_ctrl_wdata | input | 2 | {function mask, enable} |
| cfg_enable | output | 1 | Current enable bit |
| cfg_fmask | output | 1 | Current function mask bit |
| intx_clr | output | 1 | One-cycle request to deassert the legacy line |
| ntf_req | input | 1 | Interrupt request from device logic |
| ntf_vec | input | 5 | Requested vector index |
| use_inc | input | 1 | Increment use count |
| use_dec | input | 1 | Decrement use count |
| use_vec | input | 5 | Vector for the use-count update |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the block with `NUM_VEC`=6 and a 4-bit use count. With six vectors, indices 6 and 7 are still expressible on the 5-bit request and use ports and in the table address. This puts the out-of-range discard and read-as-zero paths within reach, and the pending dword is only partly populated. The small count width lets random increments reach the saturation point. Holding `msg_ready` low while requests keep arriving fills the holder and exercises the drop case. Toggling it during a rescan shows that the ascending replay order survives stalls.

// File: rtl/vm_pkg.sv
package vm_pkg;
    localparam int MAX_VEC = 32;
    localparam int VIDX_W  = 5;
    localparam int PAGE_AW = 12;
    localparam int SLOT_W  = PAGE_AW - 5;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] data;
        logic [31:0] hi;
        logic [31:0] lo;
    } vm_entry_t;

    typedef enum logic [1:0] {
        W_LO   = 2'd0,
        W_HI   = 2'd1,
        W_DATA = 2'd2,
        W_CTRL = 2'd3
    } vm_word_e;
endpackage

// File: rtl/vm_table.sv
module vm_table
    import vm_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [VIDX_W-1:0] wr_vec_i,
    input  logic [1:0]        wr_word_i,
    input  logic [31:0]       wr_data_i,
    output vm_entry_t         ent_o [NUM_VEC]
);
    localparam vm_entry_t RST_ENT = '{ctrl: 32'd1, data: 32'd0, hi: 32'd0, lo: 32'd0};

    vm_entry_t ent_d [NUM_VEC];
    vm_entry_t ent_q [NUM_VEC];

    always_comb begin
        for (int i = 0; i < NUM_VEC; i++) begin
            ent_d[i] = ent_q[i];
            if (wr_en_i && wr_vec_i == VIDX_W'(i)) begin
                case (vm_word_e'(wr_word_i))
                    W_LO:    ent_d[i].lo   = wr_data_i;
                    W_HI:    ent_d[i].hi   = wr_data_i;
                    W_DATA:  ent_d[i].data = wr_data_i;
                    default: ent_d[i].ctrl = wr_data_i;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) ent_q[i] <= RST_ENT;
        end else begin
            for (int i = 0; i < NUM_VEC; i++) ent_q[i] <= ent_d[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_VEC; i++) ent_o[i] = ent_q[i];
    end
endmodule

// File: rtl/vm_usecnt.sv
module vm_usecnt
    import vm_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_i,
    input  logic               dec_i,
    input  logic [VIDX_W-1:0]  vec_i,
    output logic [NUM_VEC-1:0] inuse_o,
    output logic [NUM_VEC-1:0] zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d [NUM_VEC];
    logic [CNT_W-1:0] cnt_q [NUM_VEC];

    always_comb begin
        for (int i = 0; i < NUM_VEC; i++) begin
            cnt_d[i]   = cnt_q[i];
            zero_o[i]  = 1'b0;
            inuse_o[i] = (cnt_q[i] != '0);
            if (vec_i == VIDX_W'(i)) begin
                if (inc_i && !dec_i && cnt_q[i] != CNT_MAX) begin
                    cnt_d[i] = cnt_q[i] + 1'b1;
                end else if (dec_i && !inc_i && cnt_q[i] != '0) begin
                    cnt_d[i]  = cnt_q[i] - 1'b1;
                    zero_o[i] = (cnt_q[i] == CNT_W'(1));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) cnt_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_VEC; i++) cnt_q[i] <= cnt_d[i];
        end
    end

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_chk
        // R10
        dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_i && !inc_i && vec_i == VIDX_W'(g) && cnt_q[g] == '0) |=> (cnt_q[g] == '0));
    end
endmodule

// File: rtl/vecmsg_ctrl.sv
module vecmsg_ctrl
    import vm_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic               bus_full,
    input  logic [PAGE_AW-1:0] bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               cfg_ctrl_we,
    input  logic [1:0]         cfg_ctrl_wdata,
    output logic               cfg_enable,
    output logic               cfg_fmask,
    output logic               intx_clr,
    input  logic               ntf_req,
    input  logic [VIDX_W-1:0]  ntf_vec,
    input  logic               use_inc,
    input  logic               use_dec,
    input  logic [VIDX_W-1:0]  use_vec,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic [NUM_VEC-1:0] chk;
        logic               hold_v;
        logic [VIDX_W-1:0]  hold_vec;
        logic               msg_v;
        logic [63:0]        msg_addr;
        logic [31:0]        msg_data;
        logic               en;
        logic               fm;
        logic               intx_clr;
        logic [31:0]        rdata;
    } st_t;

    st_t st_d, st_q;

    // address decode
    logic              in_pend;
    logic [SLOT_W-1:0] tvec;
    logic [1:0]        tword;
    logic              tvec_ok;
    logic              tbl_we;
    logic              unused_addr_lsb;

    assign in_pend         = bus_addr[PAGE_AW-1];
    assign tvec            = bus_addr[PAGE_AW-2:4];
    assign tword           = bus_addr[3:2];
    assign tvec_ok         = !in_pend && (tvec < SLOT_W'(NUM_VEC));
    assign tbl_we          = bus_req && bus_we && bus_full && tvec_ok;
    assign unused_addr_lsb = ^bus_addr[1:0];

    vm_entry_t          ent [NUM_VEC];
    logic [NUM_VEC-1:0] inuse;
    logic [NUM_VEC-1:0] zero_evt;

    vm_table #(.NUM_VEC(NUM_VEC)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (tbl_we),
        .wr_vec_i  (tvec[VIDX_W-1:0]),
        .wr_word_i (tword),
        .wr_data_i (bus_wdata),
        .ent_o     (ent)
    );

    vm_usecnt #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_usecnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (use_inc),
        .dec_i   (use_dec),
        .vec_i   (use_vec),
        .inuse_o (inuse),
        .zero_o  (zero_evt)
    );

    // per-vector views and selections
    logic [NUM_VEC-1:0] vmask;
    logic [NUM_VEC-1:0] sel_oh;
    logic [NUM_VEC-1:0] hold_oh;
    logic [NUM_VEC-1:0] wr_oh;
    vm_entry_t          sel_ent;
    vm_entry_t          hold_ent;
    logic [31:0]        rd_val;
    logic               out_free;

    assign sel_oh   = st_q.chk & (~st_q.chk + 1'b1);
    assign out_free = !st_q.msg_v || msg_ready;

    always_comb begin
        sel_ent  = '0;
        hold_ent = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            vmask[i]   = ent[i].ctrl[0];
            hold_oh[i] = st_q.hold_v && (st_q.hold_vec == VIDX_W'(i));
            wr_oh[i]   = tbl_we && (tvec == SLOT_W'(i));
            if (sel_oh[i])  sel_ent  = sel_ent  | ent[i];
            if (hold_oh[i]) hold_ent = hold_ent | ent[i];
        end
    end

    always_comb begin
        rd_val = '0;
        if (in_pend) begin
            if (bus_addr[PAGE_AW-2:2] == '0) rd_val = 32'(st_q.pend);
        end else begin
            for (int i = 0; i < NUM_VEC; i++) begin
                if (tvec == SLOT_W'(i)) begin
                    case (vm_word_e'(tword))
                        W_LO:    rd_val = ent[i].lo;
                        W_HI:    rd_val = ent[i].hi;
                        W_DATA:  rd_val = ent[i].data;
                        default: rd_val = ent[i].ctrl;
                    endcase
                end
            end
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.intx_clr = 1'b0;

        if (bus_req && !bus_we) st_d.rdata = bus_full ? rd_val : 32'd0;

        if (st_q.msg_v && msg_ready) st_d.msg_v = 1'b0;

        if (out_free) begin
            if (|st_q.chk) begin
                st_d.chk = st_q.chk & ~sel_oh;
                if (!st_q.fm && |(sel_oh & ~vmask & st_q.pend)) begin
                    st_d.pend     = st_q.pend & ~sel_oh;
                    st_d.msg_v    = 1'b1;
                    st_d.msg_addr = {sel_ent.hi, sel_ent.lo};
                    st_d.msg_data = sel_ent.data;
                end
            end else if (st_q.hold_v) begin
                st_d.hold_v = 1'b0;
                if (|(hold_oh & inuse)) begin
                    if (st_q.fm || |(hold_oh & vmask)) begin
                        st_d.pend = st_q.pend | hold_oh;
                    end else begin
                        st_d.msg_v    = 1'b1;
                        st_d.msg_addr = {hold_ent.hi, hold_ent.lo};
                        st_d.msg_data = hold_ent.data;
                    end
                end
            end
        end

        if (ntf_req && !st_d.hold_v) begin
            st_d.hold_v   = 1'b1;
            st_d.hold_vec = ntf_vec;
        end

        if (cfg_ctrl_we) begin
            st_d.en = cfg_ctrl_wdata[0];
            st_d.fm = cfg_ctrl_wdata[1];
            if (cfg_ctrl_wdata[0]) st_d.intx_clr = 1'b1;
            if (cfg_ctrl_wdata[0] && !cfg_ctrl_wdata[1]) st_d.chk = '1;
        end

        st_d.chk  = st_d.chk | wr_oh;
        st_d.pend = st_d.pend & ~zero_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign cfg_enable = st_q.en;
    assign cfg_fmask  = st_q.fm;
    assign intx_clr   = st_q.intx_clr;
    assign msg_valid  = st_q.msg_v;
    assign msg_addr   = st_q.msg_addr;
    assign msg_data   = st_q.msg_data;

    // R7
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R7
    msg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(st_q.hold_v || (|st_q.chk)));

    // R9
    intx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intx_clr |-> $past(cfg_ctrl_we && cfg_ctrl_wdata[0]));

    // R9
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ctrl_we |=> ($stable(cfg_enable) && $stable(cfg_fmask)));
endmodule

// File: tb/vecmsg_ctrl_bench.sv
module vecmsg_ctrl_bench;
    localparam int NV    = 6;
    localparam int CW    = 4;
    localparam int UMAX  = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_we = 0, bus_full = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_ctrl_we = 0;
    logic [1:0]  cfg_ctrl_wdata = '0;
    logic        cfg_enable, cfg_fmask, intx_clr;
    logic        ntf_req = 0;
    logic [4:0]  ntf_vec = '0;
    logic        use_inc = 0, use_dec = 0;
    logic [4:0]  use_vec = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    always #2 clk = ~clk;

    vecmsg_ctrl #(.NUM_VEC(NV), .CNT_W(CW)) u_vecmsg_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_full(bus_full),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_ctrl_we(cfg_ctrl_we), .cfg_ctrl_wdata(cfg_ctrl_wdata),
        .cfg_enable(cfg_enable), .cfg_fmask(cfg_fmask), .intx_clr(intx_clr),
        .ntf_req(ntf_req), .ntf_vec(ntf_vec),
        .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model
    logic [31:0] m_lo [NV];
    logic [31:0] m_hi [NV];
    logic [31:0] m_dat [NV];
    logic [31:0] m_ctl [NV];
    bit          m_pend [NV];
    int          m_use [NV];
    bit          m_en, m_fm;
    logic [95:0] expq [$];

    task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_masked(input int v);
        return m_fm || m_ctl[v][0];
    endfunction

    function automatic logic [31:0] m_pend_word();
        logic [31:0] w = '0;
        for (int v = 0; v < NV; v++) w[v] = m_pend[v];
        return w;
    endfunction

    function automatic logic [31:0] m_read(input int v, input int w);
        if (v >= NV) return 32'd0;
        case (w)
            0: return m_lo[v];
            1: return m_hi[v];
            2: return m_dat[v];
            default: return m_ctl[v];
        endcase
    endfunction

    task automatic m_emit(input int v);
        expq.push_back({m_hi[v], m_lo[v], m_dat[v]});
    endtask

    task automatic m_notify(input int v);
        if (v >= NV || m_use[v] == 0) return;
        if (m_masked(v)) m_pend[v] = 1;
        else m_emit(v);
    endtask

    task automatic m_tblwr(input int v, input int w, input logic [31:0] d);
        if (v >= NV) return;
        case (w)
            0: m_lo[v] = d;
            1: m_hi[v] = d;
            2: m_dat[v] = d;
            default: m_ctl[v] = d;
        endcase
        if (!m_masked(v) && m_pend[v]) begin
            m_pend[v] = 0;
            m_emit(v);
        end
    endtask

    task automatic m_cfg(input bit en, input bit fm);
        m_en = en;
        m_fm = fm;
        if (en && !fm) begin
            for (int v = 0; v < NV; v++) begin
                if (!m_ctl[v][0] && m_pend[v]) begin
                    m_pend[v] = 0;
                    m_emit(v);
                end
            end
        end
    endtask

    // message monitor: compares every accepted message against the model order
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (expq.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R7 unexpected message act=%h exp=none", {msg_addr, msg_data});
            end else begin
                check("R7 message payload/order", {msg_addr, msg_data}, expq.pop_front());
            end
        end
    end

    // driver tasks
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input bit full);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_full = full; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input bit full, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_full = full; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata;
    endtask

    task automatic tbl_wr(input int v, input int w, input logic [31:0] d);
        bus_wr(12'(v * 16 + w * 4), d, 1'b1);
        m_tblwr(v, w, d);
    endtask

    task automatic tbl_chk(input string tag, input int v, input int w);
        logic [31:0] d;
        bus_rd(12'(v * 16 + w * 4), 1'b1, d);
        check(tag, 96'(d), 96'(m_read(v, w)));
    endtask

    task automatic pend_chk(input string tag);
        logic [31:0] d;
        bus_rd(12'h800, 1'b1, d);
        check(tag, 96'(d), 96'(m_pend_word()));
    endtask

    task automatic cfg_wr(input bit en, input bit fm, output bit ic);
        @(negedge clk);
        cfg_ctrl_we = 1; cfg_ctrl_wdata = {fm, en};
        @(negedge clk);
        cfg_ctrl_we = 0;
        ic = intx_clr;
        m_cfg(en, fm);
    endtask

    task automatic ntf_drive(input int v);
        @(negedge clk);
        ntf_req = 1; ntf_vec = 5'(v);
        @(negedge clk);
        ntf_req = 0;
    endtask

    task automatic notify(input int v);
        ntf_drive(v);
        m_notify(v);
    endtask

    task automatic use_op(input bit inc, input int v);
        @(negedge clk);
        use_inc = inc; use_dec = !inc; use_vec = 5'(v);
        @(negedge clk);
        use_inc = 0; use_dec = 0;
        if (v < NV) begin
            if (inc && m_use[v] < UMAX) m_use[v]++;
            else if (!inc && m_use[v] > 0) begin
                m_use[v]--;
                if (m_use[v] == 0) m_pend[v] = 0;
            end
        end
    endtask

    task automatic settle(input bool_rand);
        if (bool_rand) begin
            repeat (4) begin
                @(negedge clk);
                msg_ready = 1'($urandom % 2);
            end
        end
        @(negedge clk);
        msg_ready = 1'b1;
        repeat (NV + 6) @(negedge clk);
        check("R7 all expected messages delivered", 96'(expq.size()), 96'd0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        bit ic;
        void'($urandom(32'h1c3a_5e07));
        for (int v = 0; v < NV; v++) begin
            m_lo[v] = '0; m_hi[v] = '0; m_dat[v] = '0; m_ctl[v] = 32'd1;
            m_pend[v] = 0; m_use[v] = 0;
        end
        m_en = 0; m_fm = 0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R4 reset state
        check("R4 msg_valid after reset", 96'(msg_valid), 96'd0);
        check("R4 enable/fmask after reset", 96'({cfg_enable, cfg_fmask}), 96'd0);
        tbl_chk("R4 ctrl word of vector 0", 0, 3);
        tbl_chk("R4 ctrl word of last vector", NV - 1, 3);
        tbl_chk("R4 low address cleared", 2, 0);
        pend_chk("R4 pending array cleared");

        // R1 layout and read-back
        for (int v = 0; v < NV; v++) begin
            tbl_wr(v, 0, $urandom);
            tbl_wr(v, 1, $urandom);
            tbl_wr(v, 2, $urandom);
            tbl_wr(v, 3, {$urandom} | 32'd1);
        end
        for (int w = 0; w < 4; w++) tbl_chk("R1 table word read-back", NV - 1, w);

        // R2 narrow accesses
        bus_wr(12'(16 * 5), 32'hdead_beef, 1'b0);
        tbl_chk("R2 narrow write dropped", 5, 0);
        bus_rd(12'(16 * 5 + 8), 1'b0, d);
        check("R2 narrow read returns 0", 96'(d), 96'd0);

        // R3 out-of-range slots and pending region
        bus_wr(12'(16 * NV), 32'h1234_5678, 1'b1);
        tbl_chk("R3 unconfigured slot reads 0", NV, 0);
        bus_rd(12'h804, 1'b1, d);
        check("R3 other pending dword reads 0", 96'(d), 96'd0);
        bus_wr(12'h800, 32'hffff_ffff, 1'b1);
        pend_chk("R3 pending write ignored");

        // R5 request with zero use count
        notify(1);
        settle(0);
        pend_chk("R5 unused vector leaves pending clear");
        for (int v = 0; v < NV + 2; v++) use_op(1, v);

        // R9 enable pulses intx_clr
        cfg_wr(1, 0, ic);
        check("R9 intx_clr pulse", 96'(ic), 96'd1);
        @(negedge clk);
        check("R9 intx_clr single cycle", 96'(intx_clr), 96'd0);

        // R6 masked request pends; R8 unmask replays
        notify(2);
        settle(0);
        pend_chk("R6 masked request sets pending");
        tbl_wr(2, 3, 32'd0);
        settle(0);
        pend_chk("R8 unmask clears pending");

        // R5 out-of-range request
        notify(NV + 1);
        settle(0);
        pend_chk("R5 out-of-range request discarded");

        // R9 ascending rescan under stalls
        tbl_wr(0, 3, 32'd0);
        tbl_wr(1, 3, 32'd0);
        tbl_wr(3, 3, 32'd0);
        cfg_wr(1, 1, ic);
        notify(3); notify(1); notify(0);
        settle(0);
        pend_chk("R6 function mask pends requests");
        cfg_wr(1, 0, ic);
        settle(1);
        pend_chk("R9 rescan clears replayed pending");

        // R10 dropping use to zero clears pending
        while (m_use[4] > 1) use_op(0, 4);
        notify(4);
        settle(0);
        pend_chk("R10 vector 4 pending");
        use_op(0, 4);
        pend_chk("R10 count to zero clears pending");
        use_op(0, 4);
        tbl_wr(4, 3, 32'd0);
        notify(4);
        settle(0);
        pend_chk("R10 no replay after count cleared");

        // R11 holder and R7 stall stability
        @(negedge clk);
        msg_ready = 1'b0;
        notify(0);
        @(negedge clk);
        notify(1);
        ntf_drive(2);
        repeat (2) @(negedge clk);
        d = msg_data;
        check("R7 valid held under stall", 96'(msg_valid), 96'd1);
        @(negedge clk);
        check("R7 payload stable under stall", 96'(msg_data), 96'(d));
        check("R11 first message is vector 0", 96'(d), 96'(m_dat[0]));
        settle(0);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 8);
            int v  = int'($urandom % 8);
            case (op)
                0, 1: notify(v);
                2: tbl_wr(v, 3, ($urandom & 32'hffff_fffe) | 32'($urandom % 2));
                3: begin
                    if ($urandom % 4 == 0) bus_wr(12'(v * 16), $urandom, 1'b0);
                    else tbl_wr(v, int'($urandom % 3), $urandom);
                end
                4: cfg_wr(1'($urandom % 4 != 0), 1'($urandom % 3 == 0), ic);
                5: use_op(1, v);
                6: use_op(0, v);
                default: begin
                    if ($urandom % 3 == 0) pend_chk("R3 random pending read");
                    else tbl_chk("R1 random table read", v, int'($urandom % 4));
                end
            endcase
            settle(1);
        end
        pend_chk("R6 final pending state");

        finish_run();
    end
endmodule